// File: doc/BRIEF.md
# Masked Expand-Load Unit

This block fills a 128-bit vector result from a run of elements packed back to back in memory. A command carries a byte base address, an 8-bit lane mask, an element width (32 or 64 bits), a merge-or-zero choice and a 128-bit source vector. The unit walks the lanes from the lowest index up. Each lane whose mask bit is set takes the next unread element of the packed run. Every lane whose mask bit is clear takes either its slice of the source vector or zero, and uses no memory.

Memory is read through a request/response port that carries one element per request. A request is held until the memory accepts it, and the unit then waits for the read data before it moves on. When every active lane has been filled, the unit raises `done` for one cycle and keeps the result on `result` until the next command is accepted. Any command that arrives while the unit is busy is dropped.

Top module: `expand_load_unit`

## Requirements
- R1: While reset is applied and just after it is released, `busy`, `done` and `mem_req` are low and `result` is all zeros.
- R2: Active lanes are served in ascending lane order. The first request goes to the base address, and each later request goes to the byte that follows the previous element: the base plus k times the element size in bytes for the k-th active lane, counting from 0.
- R3: The memory offset advances only on active lanes. The number of read requests equals the number of active lanes, and an inactive lane consumes no memory.
- R4: `cmd_wide`=0 selects 32-bit elements: 4 lanes, controlled by mask bits 0 to 3. `cmd_wide`=1 selects 64-bit elements: 2 lanes, controlled by mask bits 0 to 1. Mask bits above the lane count have no effect on the requests or on the result.
- R5: With `cmd_zero`=0 (merge), an inactive lane takes the matching bits of `cmd_src`.
- R6: With `cmd_zero`=1 (zero), an inactive lane is cleared to zero.
- R7: The base address may be any byte address, odd ones included. Address arithmetic wraps modulo 2^32.
- R8: Lane j of width W occupies `result[j*W+W-1 : j*W]`. A 32-bit element is taken from `mem_rdata[31:0]`, and a 64-bit element from all of `mem_rdata`. `mem_size` is 1 for 64-bit reads and 0 for 32-bit reads.
- R9: While `mem_req` is high and `mem_ack` is low, the request stays high and `mem_addr` does not change in the next cycle.
- R10: A command with no active lane raises `done` in the cycle after it is accepted and issues no memory request.
- R11: `busy` is high from the cycle after acceptance up to and including the `done` cycle. A `cmd_valid` seen while `busy` is high is ignored.
- R12: `done` lasts exactly one cycle. `result` holds its value after `done` until a new command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_base | input | 32 | Byte address of the first packed element |
| cmd_mask | input | 8 | Lane mask, bit j selects lane j |
| cmd_wide | input | 1 | 1 = 64-bit elements, 0 = 32-bit elements |
| cmd_zero | input | 1 | 1 = clear inactive lanes, 0 = merge from source |
| cmd_src | input | 128 | Source vector used for merge |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Byte address of the requested element |
| mem_size | output | 1 | 1 = 64-bit read, 0 = 32-bit read |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 128 | Assembled vector |

## Verification
The bench uses sparse masks such as 1010 and 0101. With these, a design that advanced the offset on every lane, rather than only on active ones, would read the wrong addresses and place the wrong data. It sets mask bits above the lane count in both widths, so a unit that decoded those bits would issue extra requests into lanes that do not exist. An odd base close to the top of the address space tests both unaligned addressing and wraparound. Empty masks in both modes check the one-cycle completion and the merge/zero fill, a memory that stalls its accept exposes a request that drifts before it is taken, and commands injected while busy would corrupt the result if they were not dropped.

// File: rtl/elu_pkg.sv
package elu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_FIN  = 2'd3
  } elu_state_e;

  localparam int unsigned SLICE_W = 32;
endpackage

// File: rtl/elu_rst_sync.sv
module elu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/elu_lane_pick.sv
module elu_lane_pick #(
  parameter  int LANES = 4,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] pend,
  output logic [LANES-1:0] first_oh,
  output logic [IDX_W-1:0] first_idx,
  output logic             any
);
  // isolate the lowest pending lane
  always_comb begin
    first_oh = pend & (~pend + LANES'(1));
    any      = |pend;
  end

  always_comb begin
    first_idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) first_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/elu_result_reg.sv
module elu_result_reg
  import elu_pkg::*;
#(
  parameter  int VEC_W  = 128,
  parameter  int DATA_W = 64,
  localparam int CHUNKS = VEC_W / SLICE_W,
  localparam int IDX_W  = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              init_en,
  input  logic [VEC_W-1:0]  init_val,
  input  logic              wr_en,
  input  logic              wr_wide,
  input  logic [IDX_W-1:0]  wr_lane,
  input  logic [DATA_W-1:0] wr_data,
  output logic [VEC_W-1:0]  q
);
  logic [VEC_W-1:0] q_d;

  for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
    logic hit;
    logic [SLICE_W-1:0] wdat;
    always_comb begin
      hit  = wr_wide ? (wr_lane == IDX_W'(c / 2)) : (wr_lane == IDX_W'(c));
      wdat = wr_wide ? wr_data[SLICE_W*(c % 2) +: SLICE_W] : wr_data[SLICE_W-1:0];
      if (init_en)           q_d[SLICE_W*c +: SLICE_W] = init_val[SLICE_W*c +: SLICE_W];
      else if (wr_en && hit) q_d[SLICE_W*c +: SLICE_W] = wdat;
      else                   q_d[SLICE_W*c +: SLICE_W] = q[SLICE_W*c +: SLICE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)                q <= '0;
    else if (init_en || wr_en)  q <= q_d;
  end

  // R12
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!init_en && !wr_en) |=> $stable(q));
endmodule

// File: rtl/expand_load_unit.sv
module expand_load_unit
  import elu_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int VEC_W  = 128,
  parameter  int MASK_W = 8,
  parameter  int DATA_W = 64,
  localparam int LANES_N = VEC_W / SLICE_W,
  localparam int LANES_W = VEC_W / DATA_W,
  localparam int IDX_W   = (LANES_N > 1) ? $clog2(LANES_N) : 1,
  localparam int CNT_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [MASK_W-1:0] cmd_mask,
  input  logic              cmd_wide,
  input  logic              cmd_zero,
  input  logic [VEC_W-1:0]  cmd_src,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_size,
  input  logic              mem_ack,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [VEC_W-1:0]  result
);
  logic rst_sn;
  elu_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  elu_state_e         state_q, state_d;
  logic [LANES_N-1:0] pend_q, pend_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic               wide_q, wide_d;

  logic               accept;
  logic [LANES_N-1:0] eff_mask;
  logic [LANES_N-1:0] first_oh;
  logic [IDX_W-1:0]   first_idx;
  logic               any_pend;
  logic [LANES_N-1:0] pend_after;
  logic               unused_mask_hi;

  assign unused_mask_hi = ^cmd_mask[MASK_W-1:LANES_N];

  // mask bits beyond the lane count of the selected width are dropped
  for (genvar i = 0; i < LANES_N; i++) begin : g_eff
    assign eff_mask[i] = cmd_mask[i] && (cmd_wide ? (i < LANES_W) : 1'b1);
  end

  elu_lane_pick #(.LANES(LANES_N)) u_pick (
    .pend(pend_q), .first_oh(first_oh), .first_idx(first_idx), .any(any_pend)
  );

  assign accept     = (state_q == ST_IDLE) && cmd_valid;
  assign pend_after = pend_q & ~first_oh;

  // next-state process
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    cnt_d   = cnt_q;
    base_d  = base_q;
    wide_d  = wide_q;
    case (state_q)
      ST_IDLE: if (cmd_valid) begin
        base_d  = cmd_base;
        wide_d  = cmd_wide;
        pend_d  = eff_mask;
        cnt_d   = '0;
        state_d = (|eff_mask) ? ST_REQ : ST_FIN;
      end
      ST_REQ:  if (mem_ack) state_d = ST_WAIT;
      ST_WAIT: if (mem_rvalid) begin
        pend_d  = pend_after;
        cnt_d   = cnt_q + CNT_W'(1);
        state_d = (|pend_after) ? ST_REQ : ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      cnt_q   <= '0;
      base_q  <= '0;
      wide_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
      base_q  <= base_d;
      wide_q  <= wide_d;
    end
  end

  logic [ADDR_W-1:0] offset;
  always_comb begin
    offset = wide_q ? (ADDR_W'(cnt_q) << 3) : (ADDR_W'(cnt_q) << 2);
  end

  assign mem_req  = (state_q == ST_REQ);
  assign mem_addr = base_q + offset;
  assign mem_size = wide_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_FIN);

  elu_result_reg #(.VEC_W(VEC_W), .DATA_W(DATA_W)) u_res (
    .clk(clk), .rst_sn(rst_sn),
    .init_en(accept), .init_val(cmd_zero ? '0 : cmd_src),
    .wr_en((state_q == ST_WAIT) && mem_rvalid),
    .wr_wide(wide_q), .wr_lane(first_idx), .wr_data(mem_rdata),
    .q(result)
  );

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R3
  req_has_lane_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_req |-> any_pend);
  // R3
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ((state_q == ST_WAIT) && !mem_rvalid) |=> $stable(cnt_q));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);
  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    busy |=> ($stable(base_q) && $stable(wide_q)));
  // R10
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> (pend_q == '0));
endmodule

// File: tb/sim_expand_load_unit.sv
module sim_expand_load_unit;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid;
  logic [31:0]  cmd_base;
  logic [7:0]   cmd_mask;
  logic         cmd_wide;
  logic         cmd_zero;
  logic [127:0] cmd_src;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic         mem_size;
  logic         mem_ack;
  logic         mem_rvalid;
  logic [63:0]  mem_rdata;
  logic         busy;
  logic         done;
  logic [127:0] result;

  int tests = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  expand_load_unit u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_base(cmd_base),
    .cmd_mask(cmd_mask), .cmd_wide(cmd_wide), .cmd_zero(cmd_zero),
    .cmd_src(cmd_src), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_ack(mem_ack), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .result(result)
  );

  function automatic logic [63:0] mem_word(input logic [31:0] a);
    return {a ^ 32'hC3C3_1000, a * 32'd7 + 32'h0101_0101};
  endfunction

  // memory responder
  bit          stall_mode = 0;
  int          req_n = 0;
  int          hold_err = 0;
  int          size_err = 0;
  bit          exp_size = 0;
  logic [31:0] req_log [8];

  initial begin
    bit          acc = 0;
    bit          prev_stall = 0;
    logic [31:0] acc_addr = '0;
    logic [31:0] prev_addr = '0;
    int          cyc = 0;
    mem_ack = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (prev_stall && !(mem_req && mem_addr == prev_addr)) hold_err++;
      mem_rvalid = acc;
      mem_rdata  = acc ? mem_word(acc_addr) : '0;
      acc = 0;
      mem_ack = stall_mode ? (cyc % 3 == 0) : 1'b1;
      prev_stall = mem_req && !mem_ack;
      prev_addr  = mem_addr;
      if (mem_req && mem_ack) begin
        acc = 1; acc_addr = mem_addr;
        if (mem_size != exp_size) size_err++;
        if (req_n < 8) req_log[req_n] = mem_addr;
        req_n++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // run one command and check everything it should produce
  task automatic run_cmd(input logic [127:0] src, input logic [7:0] mask,
                         input bit wide, input bit zero, input logic [31:0] base,
                         input bit stall, input bit poke, input string req,
                         output int lat);
    logic [127:0] exp_r;
    logic [31:0]  exp_a [4];
    int           n_exp = 0;
    int           lanes = wide ? 2 : 4;
    logic [31:0]  off = 0;
    int           busy_bad = 0;
    logic [127:0] held;
    exp_r = zero ? '0 : src;
    for (int j = 0; j < lanes; j++) begin
      if (mask[j]) begin
        if (wide) exp_r[64*j +: 64] = mem_word(base + off);
        else      exp_r[32*j +: 32] = mem_word(base + off)[31:0];
        exp_a[n_exp] = base + off;
        n_exp++;
        off += wide ? 8 : 4;
      end
    end
    stall_mode = stall; exp_size = wide;
    req_n = 0; hold_err = 0; size_err = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_src = src; cmd_mask = mask;
    cmd_wide = wide; cmd_zero = zero; cmd_base = base;
    @(negedge clk);
    lat = 1;
    cmd_valid = poke;
    if (poke) begin
      cmd_src = ~src; cmd_mask = 8'hFF; cmd_wide = ~wide;
      cmd_zero = ~zero; cmd_base = base + 32'h40;
    end
    while (!done && lat < 100) begin
      if (!busy) busy_bad++;
      @(negedge clk);
      lat++;
    end
    cmd_valid = 0;
    check(done == 1'b1, req, "done seen", {127'd0, done}, 128'd1);
    check(busy == 1'b1 && busy_bad == 0, "R11", "busy through run",
          busy_bad, 0);
    check(result == exp_r, req, "result", result, exp_r);
    check(req_n == n_exp, "R3", "request count", req_n, n_exp);
    for (int k = 0; k < n_exp && k < req_n; k++)
      check(req_log[k] == exp_a[k], "R2", "request address", req_log[k], exp_a[k]);
    check(size_err == 0, "R8", "mem_size", size_err, 0);
    if (stall) check(hold_err == 0, "R9", "request held under stall", hold_err, 0);
    held = result;
    @(negedge clk);
    check(done == 1'b0, "R12", "done one cycle", {127'd0, done}, 128'd0);
    @(negedge clk);
    check(result == held, "R12", "result held", result, held);
  endtask

  task automatic t_reset;
    check(busy == 0 && done == 0 && mem_req == 0, "R1", "control after reset",
          {busy, done, mem_req}, 0);
    check(result == '0, "R1", "result after reset", result, 0);
  endtask

  task automatic t_merge_sparse;
    int lat;
    run_cmd(128'h1111_2222_3333_4444_5555_6666_7777_8888, 8'b0000_1010,
            0, 0, 32'h0000_0100, 0, 0, "R5", lat);
  endtask

  task automatic t_zero_unaligned;
    int lat;
    run_cmd(128'hFFFF_EEEE_DDDD_CCCC_BBBB_AAAA_9999_8888, 8'b0000_0101,
            0, 1, 32'h0000_1003, 0, 0, "R6", lat);
  endtask

  task automatic t_wide_lane;
    int lat;
    run_cmd(128'hA5A5_A5A5_5A5A_5A5A_0123_4567_89AB_CDEF, 8'b0000_0010,
            1, 0, 32'h0000_2005, 0, 0, "R8", lat);
    run_cmd(128'h0, 8'b0000_0011, 1, 1, 32'h0000_3001, 0, 0, "R8", lat);
  endtask

  task automatic t_high_bits;
    int lat;
    run_cmd(128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555, 8'hF0,
            0, 0, 32'h0000_4000, 0, 0, "R4", lat);
    run_cmd(128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555, 8'hFC,
            1, 1, 32'h0000_4000, 0, 0, "R4", lat);
    run_cmd(128'hCAFE_0000_CAFE_1111_CAFE_2222_CAFE_3333, 8'hFE,
            1, 0, 32'h0000_4100, 0, 0, "R4", lat);
  endtask

  task automatic t_wrap;
    int lat;
    run_cmd(128'h0, 8'b0000_0011, 0, 1, 32'hFFFF_FFFD, 0, 0, "R7", lat);
  endtask

  task automatic t_empty;
    int lat;
    run_cmd(128'h0F0F_0F0F_1234_5678_9ABC_DEF0_1357_9BDF, 8'h00,
            0, 0, 32'h0000_5000, 0, 0, "R10", lat);
    check(lat == 1, "R10", "empty merge latency", lat, 1);
    run_cmd(128'h0F0F_0F0F_1234_5678_9ABC_DEF0_1357_9BDF, 8'h00,
            1, 1, 32'h0000_5000, 0, 0, "R10", lat);
    check(lat == 1, "R10", "empty zero latency", lat, 1);
  endtask

  task automatic t_stall;
    int lat;
    run_cmd(128'h0, 8'h0F, 0, 1, 32'h0000_6002, 1, 0, "R9", lat);
  endtask

  task automatic t_busy_ignore;
    int lat;
    run_cmd(128'h7777_6666_5555_4444_3333_2222_1111_0000, 8'b0000_1001,
            0, 0, 32'h0000_7000, 1, 1, "R11", lat);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_base = '0; cmd_mask = '0;
    cmd_wide = 0; cmd_zero = 0; cmd_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset;
    t_merge_sparse;
    t_zero_unaligned;
    t_wide_lane;
    t_high_bits;
    t_wrap;
    t_empty;
    t_stall;
    t_busy_ignore;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule